// File: doc/BRIEF.md
# Enhanced Parallel Port Host Transfer Engine

This block sits between a simple CPU-side register bus and the control and data lines of an enhanced parallel port. A single access to one of its transfer offsets makes it run a complete peripheral cycle by itself, with no further software steps. It lowers the write line for writes, drives the byte, pulses the data strobe or the address strobe, and watches the peripheral's wait line. The CPU request is stalled until that handshake is finished.

Accesses wider than a byte are split into consecutive byte cycles, least significant byte first. A per-byte watchdog, counted in clock cycles, ends a cycle whose peripheral never answers. It releases the CPU and sets a sticky timeout bit that software clears by writing a one to it.

A mode input chooses how the strobe is gated. In the standard mode the strobe waits for the wait line to be low. In the legacy mode it starts at once.

Top module: `epp_host`

## Requirements
- R1: While reset is low, the peripheral reset output `pp_nrst` is low. Two clocks after reset is released it is high. Whenever no transfer is running, `pp_nwrite`, `pp_ndstrb` and `pp_nastrb` are high and `pp_doe` is low.
- R2: An access at offset 3 runs one address cycle, which pulses only `pp_nastrb`. An access at offset 4 runs one data cycle, which pulses only `pp_ndstrb`.
- R3: In a write cycle, `pp_nwrite` is low and `pp_dout` holds the byte with `pp_doe` high before the strobe falls. All three stay that way for as long as the strobe is low.
- R4: With `legacy_start` low, a strobe falls only in a cycle where `pp_wait` is low. If `pp_wait` stays high, no strobe is issued at all.
- R5: With `legacy_start` high, a strobe falls even while `pp_wait` is high. A one-byte access whose peripheral answers at once raises `cpu_ready` on the fifth clock after the request is taken.
- R6: A strobe is released only after `pp_wait` has been seen high, unless the watchdog fires. In a read, the byte on `pp_din` at that point is returned on `cpu_rdata`, zero-extended.
- R7: `cpu_ready` is a one-clock pulse that ends each access. `cpu_req` is held until that pulse.
- R8: If a byte cycle waits `TMO_CYC` clocks without finishing, the access is aborted and `cpu_ready` pulses TMO_CYC+2 clocks after the request is taken. Status bit 0 is set. A read returns 0xFF in every byte lane of the access width.
- R9: Status bit 0 is read at offset 1. It stays set until a write to offset 1 with data bit 0 at one. A write with bit 0 at zero leaves it unchanged.
- R10: Offset 5 moves 16 bits as two data cycles. Offsets 6 and 7 move 32 bits as four data cycles. Bytes go out and come back least significant first.
- R11: `pp_doe` is high only during write cycles and never while a read strobe is low.
- R12: `pp_ndstrb` and `pp_nastrb` are never low together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_req | input | 1 | Access request, held until cpu_ready |
| cpu_we | input | 1 | 1 = write access, 0 = read access |
| cpu_addr | input | 3 | Register offset |
| cpu_wdata | input | 32 | Write data |
| cpu_rdata | output | 32 | Read data, valid with cpu_ready |
| cpu_ready | output | 1 | One-clock completion pulse |
| legacy_start | input | 1 | 1 = strobe start not gated by wait |
| pp_wait | input | 1 | Peripheral wait/acknowledge line |
| pp_din | input | 8 | Data bus as seen from the pads |
| pp_dout | output | 8 | Data bus value to drive |
| pp_doe | output | 1 | Data bus output enable |
| pp_nwrite | output | 1 | Active-low write direction |
| pp_ndstrb | output | 1 | Active-low data strobe |
| pp_nastrb | output | 1 | Active-low address strobe |
| pp_nrst | output | 1 | Active-low peripheral reset |

## Verification
The bench builds the engine with `TMO_CYC` set to 40 instead of the default 1250. That brings both timeout kinds into reach within a few dozen clocks: a peripheral that never raises wait, and one that holds wait high so the gated strobe never starts. With that value the bench can also check the exact abort latency of TMO_CYC+2. `BUS_BYTES` stays at 4, so both the 16-bit and the 32-bit split paths are exercised.

// File: rtl/epp_host_pkg.sv
package epp_host_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_GATE,
    ST_STRB,
    ST_REL,
    ST_FIN
  } epp_st_e;

  localparam logic [2:0] OFS_STAT = 3'd1;
  localparam logic [2:0] OFS_ADDR = 3'd3;
  localparam logic [2:0] OFS_DATA = 3'd4;
  localparam logic [2:0] OFS_HALF = 3'd5;
  localparam logic [2:0] OFS_WRD0 = 3'd6;
  localparam logic [2:0] OFS_WRD1 = 3'd7;

endpackage

// File: rtl/epp_rst_sync.sv
module epp_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic srst_n
);

  logic [1:0] sync_q;
  logic [1:0] sync_d;

  assign sync_d = {sync_q[0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign srst_n = sync_q[1];

endmodule

// File: rtl/epp_wdog.sv
module epp_wdog #(
  parameter int LIMIT = 1250
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  input  logic run,
  output logic expired
);

  localparam int CW = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;
  logic          cnt_en;

  always_comb begin
    expired = run && (cnt_q == LAST);
    cnt_en  = restart || (run && !expired);
    cnt_d   = restart ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  // R8: the count never passes the abort point
  assert_wdog_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST);

endmodule

// File: rtl/epp_seq.sv
module epp_seq
  import epp_host_pkg::*;
#(
  parameter int BYTES   = 4,
  parameter int TMO_CYC = 1250
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         start,
  input  logic                         start_local,
  input  logic                         start_we,
  input  logic                         start_adr,
  input  logic [((BYTES>1)?$clog2(BYTES):1)-1:0] start_last,
  input  logic [8*BYTES-1:0]           start_wdata,
  input  logic                         legacy,
  input  logic                         wait_i,
  input  logic [7:0]                   din,
  output logic                         idle,
  output logic                         done,
  output logic                         tmo_evt,
  output logic [8*BYTES-1:0]           rdata,
  output logic                         nwrite,
  output logic                         ndstrb,
  output logic                         nastrb,
  output logic [7:0]                   dout,
  output logic                         doe
);

  localparam int IW = (BYTES > 1) ? $clog2(BYTES) : 1;
  localparam int DW = 8 * BYTES;

  epp_st_e       st_q, st_d;
  logic [IW-1:0] idx_q, idx_d;
  logic [IW-1:0] last_q;
  logic          we_q, adr_q;
  logic [DW-1:0] wbuf_q;
  logic          load, go, cap, abort, expired, in_xfer;
  logic          wd_restart, wd_run;

  assign load = (st_q == ST_IDLE) && start;
  assign go   = legacy || !wait_i;

  always_comb begin
    st_d  = st_q;
    idx_d = idx_q;
    cap   = 1'b0;
    abort = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (start) begin
          st_d  = start_local ? ST_FIN : ST_SETUP;
          idx_d = '0;
        end
      end
      ST_SETUP: st_d = ST_GATE;
      ST_GATE: begin
        if (go) st_d = ST_STRB;
        else if (expired) begin
          st_d  = ST_FIN;
          abort = 1'b1;
        end
      end
      ST_STRB: begin
        if (wait_i) begin
          st_d = ST_REL;
          cap  = 1'b1;
        end else if (expired) begin
          st_d  = ST_FIN;
          abort = 1'b1;
        end
      end
      ST_REL: begin
        if (idx_q == last_q) st_d = ST_FIN;
        else begin
          st_d  = ST_SETUP;
          idx_d = idx_q + 1'b1;
        end
      end
      ST_FIN:  st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      idx_q <= '0;
    end else begin
      st_q  <= st_d;
      idx_q <= idx_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      we_q   <= 1'b0;
      adr_q  <= 1'b0;
      last_q <= '0;
      wbuf_q <= '0;
    end else if (load) begin
      we_q   <= start_we && !start_local;
      adr_q  <= start_adr;
      last_q <= start_last;
      wbuf_q <= start_wdata;
    end
  end

  assign wd_restart = (st_q == ST_SETUP);
  assign wd_run     = (st_q == ST_GATE) || (st_q == ST_STRB);

  epp_wdog #(.LIMIT(TMO_CYC)) i_wdog (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (wd_restart),
    .run     (wd_run),
    .expired (expired)
  );

  // one capture register per byte lane
  for (genvar g = 0; g < BYTES; g++) begin : g_lane
    logic [7:0] byte_q;
    logic [7:0] byte_d;
    logic       byte_en;

    always_comb begin
      byte_en = 1'b0;
      byte_d  = byte_q;
      if (load) begin
        byte_en = 1'b1;
        byte_d  = '0;
      end else if (abort && (IW'(g) <= last_q)) begin
        byte_en = 1'b1;
        byte_d  = 8'hFF;
      end else if (cap && (idx_q == IW'(g))) begin
        byte_en = 1'b1;
        byte_d  = din;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       byte_q <= '0;
      else if (byte_en) byte_q <= byte_d;
    end

    assign rdata[8*g +: 8] = byte_q;
  end

  assign in_xfer = (st_q == ST_SETUP) || (st_q == ST_GATE) ||
                   (st_q == ST_STRB)  || (st_q == ST_REL);
  assign doe     = we_q && in_xfer;
  assign nwrite  = !(we_q && in_xfer);
  assign dout    = doe ? wbuf_q[{idx_q, 3'b000} +: 8] : 8'h00;
  assign ndstrb  = !((st_q == ST_STRB) && !adr_q);
  assign nastrb  = !((st_q == ST_STRB) && adr_q);
  assign idle    = (st_q == ST_IDLE);
  assign done    = (st_q == ST_FIN);
  assign tmo_evt = abort;

  // R1: quiet lines outside a transfer
  assert_idle_lines_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_IDLE) |-> (nwrite && ndstrb && nastrb && !doe));
  // R3: write byte stays driven and steady under the strobe
  assert_write_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ((st_q == ST_STRB) && we_q) |-> (!nwrite && doe && $stable(dout)));
  // R4: gated start holds off while wait is high
  assert_gate_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ((st_q == ST_GATE) && !legacy && wait_i) |=> (st_q != ST_STRB));
  // R6: strobe stays low until wait goes high or watchdog fires
  assert_strobe_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ((st_q == ST_STRB) && !wait_i && !expired) |=> (st_q == ST_STRB));
  // R7: completion is a single-clock pulse
  assert_ready_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R12: strobes are mutually exclusive
  assert_strobe_excl_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !(!ndstrb && !nastrb));

endmodule

// File: rtl/epp_host.sv
module epp_host
  import epp_host_pkg::*;
#(
  parameter int TMO_CYC   = 1250,
  parameter int BUS_BYTES = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   cpu_req,
  input  logic                   cpu_we,
  input  logic [2:0]             cpu_addr,
  input  logic [8*BUS_BYTES-1:0] cpu_wdata,
  output logic [8*BUS_BYTES-1:0] cpu_rdata,
  output logic                   cpu_ready,
  input  logic                   legacy_start,
  input  logic                   pp_wait,
  input  logic [7:0]             pp_din,
  output logic [7:0]             pp_dout,
  output logic                   pp_doe,
  output logic                   pp_nwrite,
  output logic                   pp_ndstrb,
  output logic                   pp_nastrb,
  output logic                   pp_nrst
);

  localparam int DW = 8 * BUS_BYTES;
  localparam int IW = (BUS_BYTES > 1) ? $clog2(BUS_BYTES) : 1;

  logic          srst_n;
  logic          seq_idle, seq_done, tmo_evt;
  logic [DW-1:0] seq_rdata;
  logic          is_local, is_adr;
  logic [IW-1:0] last_idx;
  logic          accept, clr_req;
  logic          flag_q, flag_d, flag_en;
  logic          loc_q, loc_d;
  logic [DW-1:0] loc_rd_q, loc_rd_d;

  epp_rst_sync i_rst_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .srst_n (srst_n)
  );

  always_comb begin
    is_local = 1'b0;
    is_adr   = 1'b0;
    last_idx = '0;
    unique case (cpu_addr)
      OFS_ADDR: is_adr = 1'b1;
      OFS_DATA: last_idx = '0;
      OFS_HALF: last_idx = IW'(1);
      OFS_WRD0,
      OFS_WRD1: last_idx = IW'(BUS_BYTES - 1);
      default:  is_local = 1'b1;
    endcase
  end

  assign accept  = cpu_req && seq_idle;
  assign clr_req = accept && cpu_we && (cpu_addr == OFS_STAT) && cpu_wdata[0];

  always_comb begin
    flag_en = tmo_evt || clr_req;
    flag_d  = tmo_evt;
    loc_d   = is_local;
    loc_rd_d = '0;
    if (is_local && !cpu_we && (cpu_addr == OFS_STAT)) loc_rd_d = DW'(flag_q);
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n)      flag_q <= 1'b0;
    else if (flag_en) flag_q <= flag_d;
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      loc_q    <= 1'b0;
      loc_rd_q <= '0;
    end else if (accept) begin
      loc_q    <= loc_d;
      loc_rd_q <= loc_rd_d;
    end
  end

  epp_seq #(.BYTES(BUS_BYTES), .TMO_CYC(TMO_CYC)) i_seq (
    .clk         (clk),
    .rst_n       (srst_n),
    .start       (accept),
    .start_local (is_local),
    .start_we    (cpu_we),
    .start_adr   (is_adr),
    .start_last  (last_idx),
    .start_wdata (cpu_wdata),
    .legacy      (legacy_start),
    .wait_i      (pp_wait),
    .din         (pp_din),
    .idle        (seq_idle),
    .done        (seq_done),
    .tmo_evt     (tmo_evt),
    .rdata       (seq_rdata),
    .nwrite      (pp_nwrite),
    .ndstrb      (pp_ndstrb),
    .nastrb      (pp_nastrb),
    .dout        (pp_dout),
    .doe         (pp_doe)
  );

  assign cpu_rdata = loc_q ? loc_rd_q : seq_rdata;
  assign cpu_ready = seq_done;
  assign pp_nrst   = srst_n;

  // R8: the sticky bit only rises after an aborted cycle
  assert_flag_set_R8: assert property (@(posedge clk) disable iff (!srst_n)
    $rose(flag_q) |-> $past(tmo_evt));
  // R9: the sticky bit only falls after a write of one to the status offset
  assert_flag_clear_R9: assert property (@(posedge clk) disable iff (!srst_n)
    $fell(flag_q) |-> $past(clr_req));
  // R11: the bus is only driven while the write line is low
  assert_oe_write_R11: assert property (@(posedge clk) disable iff (!srst_n)
    pp_doe |-> !pp_nwrite);

endmodule

// File: tb/test_epp_host.sv
`timescale 1ns/1ps
module test_epp_host;

  localparam int TMO = 40;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cpu_req = 1'b0, cpu_we = 1'b0;
  logic [2:0]  cpu_addr = '0;
  logic [31:0] cpu_wdata = '0;
  logic [31:0] cpu_rdata;
  logic        cpu_ready;
  logic        legacy = 1'b0;
  logic        pp_wait;
  logic [7:0]  pp_din;
  logic [7:0]  pp_dout;
  logic        pp_doe, pp_nwrite, pp_ndstrb, pp_nastrb, pp_nrst;

  always #4 clk = ~clk;

  epp_host #(.TMO_CYC(TMO), .BUS_BYTES(4)) i_epp_host (
    .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_we(cpu_we),
    .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
    .cpu_ready(cpu_ready), .legacy_start(legacy), .pp_wait(pp_wait),
    .pp_din(pp_din), .pp_dout(pp_dout), .pp_doe(pp_doe),
    .pp_nwrite(pp_nwrite), .pp_ndstrb(pp_ndstrb), .pp_nastrb(pp_nastrb),
    .pp_nrst(pp_nrst)
  );

  int n_tests = 0, n_fail = 0;
  bit fin_flag = 0;

  int ack_dly = 0, hold_high = 0, acnt = 0;
  bit stuck = 0, expect_tmo = 0;
  logic [9:0] cap_q[$];   // {address strobe, write, byte}
  logic [7:0] rd_q[$];
  logic [9:0] cur = '0;
  bit prev_low = 0, prev_low_m = 0, low_p = 0, low_m = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // peripheral model: answers strobes, records each finished byte cycle
  initial begin
    pp_wait = 1'b0;
    pp_din  = 8'h00;
    forever begin
      @(negedge clk);
      #1;
      low_p = !pp_ndstrb || !pp_nastrb;
      if (prev_low && !low_p) begin
        cap_q.push_back(cur);
        if (!cur[8] && rd_q.size() > 0) void'(rd_q.pop_front());
      end
      if (low_p) begin
        pp_din = (rd_q.size() > 0) ? rd_q[0] : 8'h00;
        cur = {!pp_nastrb, !pp_nwrite, (!pp_nwrite) ? pp_dout : pp_din};
      end
      if (hold_high > 0) begin
        pp_wait = 1'b1;
        hold_high--;
      end else if (low_p) begin
        if (!stuck) begin
          if (acnt >= ack_dly) pp_wait = 1'b1;
          else acnt++;
        end
      end else begin
        acnt = 0;
        pp_wait = 1'b0;
      end
      prev_low = low_p;
    end
  end

  // per-clock protocol monitor
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n) begin
        low_m = !pp_ndstrb || !pp_nastrb;
        if (low_m) begin
          chk("R12 strobes exclusive", {31'b0, pp_ndstrb | pp_nastrb}, 32'd1);
          if (!pp_nwrite) chk("R3 bus driven under write strobe", {31'b0, pp_doe}, 32'd1);
          else chk("R11 bus released under read strobe", {31'b0, pp_doe}, 32'd0);
          if (!prev_low_m && !legacy) chk("R4 strobe starts with wait low", {31'b0, pp_wait}, 32'd0);
        end
        if (prev_low_m && !low_m && !expect_tmo)
          chk("R6 strobe ends after wait high", {31'b0, pp_wait}, 32'd1);
        prev_low_m = low_m;
      end
    end
  end

  task automatic acc(input bit we, input logic [2:0] a, input logic [31:0] wd,
                     output logic [31:0] rd, output int lat);
    @(negedge clk);
    cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = wd;
    lat = 0;
    do begin
      @(negedge clk);
      lat++;
    end while (!cpu_ready && lat < 5000);
    rd = cpu_rdata;
    cpu_req = 1'b0;
    @(negedge clk);
    chk("R7 ready lasts one clock", {31'b0, cpu_ready}, 32'd0);
    chk("R1 lines idle after access", {28'b0, pp_nwrite, pp_ndstrb, pp_nastrb, pp_doe}, 32'hE);
  endtask

  task automatic chk_cap(input string tag, input int i, input logic [9:0] exp);
    if (cap_q.size() > i) chk(tag, {22'b0, cap_q[i]}, {22'b0, exp});
    else chk(tag, 32'hDEAD, {22'b0, exp});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!fin_flag) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog run did not finish actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    int lat, lat_new;
    #20;
    chk("R1 peripheral reset low during reset", {31'b0, pp_nrst}, 32'd0);
    @(negedge clk); rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 peripheral reset high after release", {31'b0, pp_nrst}, 32'd1);
    chk("R1 idle lines after reset", {28'b0, pp_nwrite, pp_ndstrb, pp_nastrb, pp_doe}, 32'hE);
    chk("R7 no ready after reset", {31'b0, cpu_ready}, 32'd0);

    // R2 R3 address write
    cap_q.delete(); ack_dly = 0;
    acc(1, 3'd3, 32'h5A, rd, lat);
    chk("R5 single byte latency", lat, 5);
    chk("R2 one cycle for address write", cap_q.size(), 1);
    chk_cap("R2 address strobe write byte", 0, {1'b1, 1'b1, 8'h5A});

    // R2 R3 data write
    cap_q.delete(); ack_dly = 2;
    acc(1, 3'd4, 32'hC3, rd, lat);
    chk_cap("R2 data strobe write byte", 0, {1'b0, 1'b1, 8'hC3});

    // R6 data read
    cap_q.delete(); ack_dly = 3; rd_q.push_back(8'h9E);
    acc(0, 3'd4, 32'h0, rd, lat);
    chk("R6 data read value", rd, 32'h9E);
    chk_cap("R2 data strobe read", 0, {1'b0, 1'b0, 8'h9E});

    // R6 address read
    cap_q.delete(); ack_dly = 1; rd_q.push_back(8'h21);
    acc(0, 3'd3, 32'h0, rd, lat);
    chk("R6 address read value", rd, 32'h21);
    chk_cap("R2 address strobe read", 0, {1'b1, 1'b0, 8'h21});

    // R10 16-bit write
    cap_q.delete(); ack_dly = 0;
    acc(1, 3'd5, 32'h1234BEEF, rd, lat);
    chk("R10 half word byte count", cap_q.size(), 2);
    chk_cap("R10 half word low byte first", 0, {1'b0, 1'b1, 8'hEF});
    chk_cap("R10 half word high byte", 1, {1'b0, 1'b1, 8'hBE});

    // R10 32-bit read
    cap_q.delete(); ack_dly = 2;
    rd_q.push_back(8'h11); rd_q.push_back(8'h22); rd_q.push_back(8'h33); rd_q.push_back(8'h44);
    acc(0, 3'd6, 32'h0, rd, lat);
    chk("R10 word read assembly", rd, 32'h44332211);
    chk("R10 word read byte count", cap_q.size(), 4);

    // R10 32-bit write at offset 7
    cap_q.delete(); ack_dly = 0;
    acc(1, 3'd7, 32'hA1B2C3D4, rd, lat);
    chk_cap("R10 word write byte 0", 0, {1'b0, 1'b1, 8'hD4});
    chk_cap("R10 word write byte 1", 1, {1'b0, 1'b1, 8'hC3});
    chk_cap("R10 word write byte 2", 2, {1'b0, 1'b1, 8'hB2});
    chk_cap("R10 word write byte 3", 3, {1'b0, 1'b1, 8'hA1});

    acc(0, 3'd1, 32'h0, rd, lat);
    chk("R9 status clear before any timeout", rd, 32'h0);

    // R4 gated start with wait held high
    cap_q.delete(); hold_high = 8; legacy = 1'b0;
    acc(1, 3'd4, 32'h77, rd, lat_new);
    chk("R4 start delayed by wait high", {31'b0, lat_new > 8}, 32'd1);
    chk_cap("R4 byte after gated start", 0, {1'b0, 1'b1, 8'h77});

    // R5 legacy start with wait already high
    cap_q.delete(); hold_high = 8; legacy = 1'b1;
    acc(1, 3'd4, 32'h66, rd, lat);
    chk("R5 legacy start ignores wait", lat, 5);
    chk_cap("R5 byte in legacy mode", 0, {1'b0, 1'b1, 8'h66});
    repeat (10) @(negedge clk);
    legacy = 1'b0; hold_high = 0;

    // R8 timeout on read
    cap_q.delete(); stuck = 1; expect_tmo = 1;
    acc(0, 3'd4, 32'h0, rd, lat);
    chk("R8 timed out read returns all ones", rd, 32'hFF);
    chk("R8 timeout latency", lat, TMO + 2);
    stuck = 0; expect_tmo = 0;
    acc(0, 3'd1, 32'h0, rd, lat);
    chk("R8 timeout sets status bit 0", rd, 32'h1);

    // R9 sticky behaviour
    acc(1, 3'd1, 32'h0, rd, lat);
    acc(0, 3'd1, 32'h0, rd, lat);
    chk("R9 write of zero keeps flag", rd, 32'h1);
    acc(1, 3'd1, 32'h1, rd, lat);
    acc(0, 3'd1, 32'h0, rd, lat);
    chk("R9 write of one clears flag", rd, 32'h0);

    // R8 timeout on 16-bit read
    stuck = 1; expect_tmo = 1;
    acc(0, 3'd5, 32'h0, rd, lat);
    chk("R8 timed out half read lanes", rd, 32'h0000FFFF);
    stuck = 0; expect_tmo = 0;
    acc(1, 3'd1, 32'h1, rd, lat);

    // R4 R8 wait stuck high in gated mode: no strobe, then abort
    cap_q.delete(); hold_high = TMO + 20;
    acc(1, 3'd4, 32'h55, rd, lat);
    chk("R8 gated timeout latency", lat, TMO + 2);
    chk("R4 no strobe while wait high", cap_q.size(), 0);
    acc(0, 3'd1, 32'h0, rd, lat);
    chk("R8 gated timeout sets flag", rd, 32'h1);
    repeat (30) @(negedge clk);
    hold_high = 0;
    acc(1, 3'd1, 32'h1, rd, lat);

    // normal traffic still works afterwards
    cap_q.delete(); ack_dly = 1; rd_q.push_back(8'hC5);
    acc(0, 3'd4, 32'h0, rd, lat);
    chk("R6 read after timeouts", rd, 32'hC5);

    fin_flag = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule